// File: doc/BRIEF.md
# Wired-AND SCL Clock Generator with Bus Synchronisation

This block produces the serial clock of a two-wire bus master whose clock line is shared by several masters through an open-drain, wired-AND connection. The block never drives the line high. It either pulls the line low or lets it go. A programmable low time and a programmable high time set the clock it would produce on its own. Because every master watches the real line level, all of them lock onto one common clock. That clock keeps the longest low time and the shortest high time of all the masters on the line.

The line level enters through a two-flop synchroniser. After the block releases the line, it does not start its high-time count. It waits in a hold phase until the synchronised level reads high, so a slower master can stretch the low half of the clock. If the synchronised level falls while the block is counting its high time, the block takes this as another master ending the high half early. It pulls the line low at once and restarts its low-time count. The low-time count always starts from the falling edge that the synchroniser observes. A one-cycle rise strobe marks the point where the high half is confirmed, and a data shifter uses it to sample. A one-cycle fall strobe marks the point where the block starts pulling low, and the shifter uses it to update data. Dropping the enable releases the line and clears both counters.

Top module: `scl_sync_gen`

## Requirements
- R1: After reset the line is released (`scl_drive_low` = 0) and neither strobe is asserted.
- R2: With enable high and the bus idle high, the block enters the hold phase on the first clock that samples enable. `rise_stb` pulses on the next clock.
- R3: `scl_drive_low` and `fall_stb` both assert exactly H clocks after the clock that raised `rise_stb`, where H is `high_period`. `fall_stb` is asserted exactly in the first cycle of every low drive.
- R4: The low-time count starts at the falling edge seen by the synchroniser. The line is released exactly L clocks after the clock that follows the first cycle with the synchronised level low, where L is `low_period`. For a master alone on the bus this gives L+3 clocks of low drive.
- R5: While the line is released and the synchronised level is low, no high-time counting takes place and `rise_stb` stays low. `rise_stb` pulses 3 clocks after the bus actually goes high. This is two synchroniser flops plus one state update.
- R6: A falling edge on the synchronised level during the high half makes the block pull low on the next clock and raise `fall_stb`. The low-time count then restarts from zero.
- R7: A master alone on the bus repeats a period of L+H+6 clocks between consecutive `rise_stb` pulses.
- R8: While enable is low, from the next clock on the line is released and no strobe occurs, whatever the bus does. Re-enabling starts a fresh high-time count of the full H clocks.
- R9: Each strobe lasts one cycle, and the two strobes are never asserted together.
- R10: A period setting of zero behaves exactly like a setting of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Clock generation on when high; the line is released when low |
| scl_in | input | 1 | Level read back from the shared clock line (asynchronous) |
| low_period | input | CNT_W | Low-time count in clocks, counted from the observed falling edge |
| high_period | input | CNT_W | High-time count in clocks, counted from the confirmed high level |
| scl_drive_low | output | 1 | 1 pulls the shared line low; 0 releases it |
| rise_stb | output | 1 | One-cycle pulse when the high half is confirmed (data sample point) |
| fall_stb | output | 1 | One-cycle pulse when the block starts pulling low (data update point) |

## Verification
The assertions assume that `scl_in` behaves like a wired-AND line. Whenever `scl_drive_low` is 1, the line reads low, and any other master only adds extra low time on top of that. They also assume that the period settings stay constant while enable is high. The bench builds the line as the AND of the block's release and a modelled second master. It changes the settings and the second master's drive only on falling clock edges. It loads new settings only together with raising enable. This keeps every stimulus inside what a real open-drain bus can do.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Phase of the generated clock as seen by this master.
    typedef enum logic [1:0] {
        PH_OFF     = 2'd0,  // disabled, line released
        PH_WAIT_HI = 2'd1,  // released, waiting for the line to read high
        PH_HIGH    = 2'd2,  // released, counting the high time
        PH_LOW     = 2'd3   // pulling low, counting the low time
    } phase_e;

    // Registered state of the generator.
    typedef struct packed {
        phase_e phase;
        logic   drive_low;
        logic   rise;
        logic   fall;
    } gen_regs_t;

endpackage

// File: rtl/scl_bus_sync.sv
module scl_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic level,
    output logic fell
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;
    logic          prev_d, prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = bus_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], bus_in};
        end
    endgenerate

    always_comb begin
        prev_d = chain_q[LAST];
    end

    // Flops come out of reset reading low, so no edge can be invented
    // from values that were present before reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level = chain_q[LAST];
    assign fell  = prev_q & ~chain_q[LAST];

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] last_val,
    output logic         hit
);

    localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d, cnt_q;
    logic         at_last;

    always_comb begin
        at_last = (cnt_q == last_val);
        cnt_d   = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && !at_last) begin
            cnt_d = cnt_q + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit = run & ~clr & at_last;

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] low_period,
    input  logic [CNT_W-1:0] high_period,
    output logic             scl_drive_low,
    output logic             rise_stb,
    output logic             fall_stb
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             bus_level;
    logic             bus_fell;
    logic [CNT_W-1:0] low_last, high_last;
    logic             low_clr, low_run, low_hit;
    logic             high_clr, high_run, high_hit;
    gen_regs_t        r_d, r_q;

    scl_bus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_in (scl_in),
        .level  (bus_level),
        .fell   (bus_fell)
    );

    // A zero setting is folded onto one clock.
    assign low_last  = (low_period  == '0) ? '0 : low_period  - ONE;
    assign high_last = (high_period == '0) ? '0 : high_period - ONE;

    // Low time runs only while the line reads low; an observed fall restarts it.
    assign low_clr  = (r_q.phase != PH_LOW) | bus_fell;
    assign low_run  = (r_q.phase == PH_LOW) & ~bus_level;
    // High time runs from the confirmed high level until done or cut short.
    assign high_clr = (r_q.phase != PH_HIGH);
    assign high_run = (r_q.phase == PH_HIGH) & ~bus_fell;

    scl_phase_cnt #(
        .W (CNT_W)
    ) u_low_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (low_clr),
        .run      (low_run),
        .last_val (low_last),
        .hit      (low_hit)
    );

    scl_phase_cnt #(
        .W (CNT_W)
    ) u_high_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (high_clr),
        .run      (high_run),
        .last_val (high_last),
        .hit      (high_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rise = 1'b0;
        r_d.fall = 1'b0;
        if (!enable) begin
            r_d.phase     = PH_OFF;
            r_d.drive_low = 1'b0;
        end else begin
            unique case (r_q.phase)
                PH_OFF: begin
                    r_d.phase     = PH_WAIT_HI;
                    r_d.drive_low = 1'b0;
                end
                PH_WAIT_HI: begin
                    if (bus_level) begin
                        r_d.phase = PH_HIGH;
                        r_d.rise  = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (bus_fell || high_hit) begin
                        r_d.phase     = PH_LOW;
                        r_d.drive_low = 1'b1;
                        r_d.fall      = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (low_hit) begin
                        r_d.phase     = PH_WAIT_HI;
                        r_d.drive_low = 1'b0;
                    end
                end
                default: begin
                    r_d.phase     = PH_OFF;
                    r_d.drive_low = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_drive_low = r_q.drive_low;
    assign rise_stb      = r_q.rise;
    assign fall_stb      = r_q.fall;

endmodule

// File: rtl/scl_sync_gen_chk.sv
module scl_sync_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_in,
    input logic scl_drive_low,
    input logic rise_stb,
    input logic fall_stb
);

    assert_stb_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    assert_rise_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);

    assert_fall_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);

    assert_fall_starts_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (scl_drive_low && !$past(scl_drive_low)));

    assert_drive_needs_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> fall_stb);

    assert_rise_seen_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (!scl_drive_low && $past(scl_in, 3)));

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !rise_stb && !fall_stb));

endmodule

bind scl_sync_gen scl_sync_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .rise_stb      (rise_stb),
    .fall_stb      (fall_stb)
);

// File: tb/scl_sync_gen_test.sv
`timescale 1ns/1ps
module scl_sync_gen_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         other_low = 1'b0;
    logic [W-1:0] low_set = '0;
    logic [W-1:0] high_set = '0;
    logic         scl_in;
    logic         scl_drive_low, rise_stb, fall_stb;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        bit    is_rise;
        int    at;
        string req;
    } ev_t;
    ev_t exp_q[$];

    // Wired-AND line: low when this master or the modelled other master pulls.
    assign scl_in = ~(scl_drive_low | other_low);

    scl_sync_gen #(.CNT_W(W), .SYNC_STAGES(2)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .scl_in        (scl_in),
        .low_period    (low_set),
        .high_period   (high_set),
        .scl_drive_low (scl_drive_low),
        .rise_stb      (rise_stb),
        .fall_stb      (fall_stb)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    task automatic push(bit is_rise, int at, string req);
        ev_t e;
        e.is_rise = is_rise;
        e.at      = at;
        e.req     = req;
        exp_q.push_back(e);
    endtask

    // Monitor side of the scoreboard.
    task automatic take(bit is_rise);
        ev_t e;
        n_checks++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R8/R9: unexpected %s strobe at cycle %0d, actual 1 expected 0",
                     is_rise ? "rise" : "fall", cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.is_rise != is_rise || e.at != cyc) begin
                n_fail++;
                $display("FAIL %s: actual %s strobe at cycle %0d expected %s strobe at cycle %0d",
                         e.req, is_rise ? "rise" : "fall", cyc,
                         e.is_rise ? "rise" : "fall", e.at);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rise_stb) take(1'b1);
            if (fall_stb) take(1'b0);
        end
    end

    task automatic wait_to(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic start(int l, int h, output int c);
        low_set  = W'(l);
        high_set = W'(h);
        enable   = 1'b1;
        c        = cyc;
    endtask

    task automatic stop_at(int n);
        wait_to(n);
        enable = 1'b0;
    endtask

    task automatic settle(string req);
        wait_to(cyc + 12);
        check(req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        int c2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_to(6);

        // R1: reset state
        check("R1 drive", scl_drive_low, 0);
        check("R1 rise", rise_stb, 0);
        check("R1 fall", fall_stb, 0);

        // Alone on the bus, L=5 H=4: R2 R3 R4 R7
        start(5, 4, c);
        push(1'b1, c + 2,  "R2");
        push(1'b0, c + 6,  "R3");
        push(1'b1, c + 17, "R7");
        push(1'b0, c + 21, "R3");
        push(1'b1, c + 32, "R7");
        push(1'b0, c + 36, "R3");
        wait_to(c + 6);  check("R3 drive on", scl_drive_low, 1);
        wait_to(c + 13); check("R4 still low", scl_drive_low, 1);
        wait_to(c + 14); check("R4 released", scl_drive_low, 0);
        stop_at(c + 37);
        wait_to(c + 38); check("R8 release on disable", scl_drive_low, 0);
        settle("R7 all events");

        // Zero high setting, L=3 H=0: R10
        start(3, 0, c);
        push(1'b1, c + 2,  "R2");
        push(1'b0, c + 3,  "R10");
        push(1'b1, c + 12, "R10");
        push(1'b0, c + 13, "R10");
        wait_to(c + 3); check("R10 drive on", scl_drive_low, 1);
        wait_to(c + 9); check("R4 released L=3", scl_drive_low, 0);
        stop_at(c + 14);
        settle("R10 all events");

        // Other master stretches the low half: R5
        start(4, 3, c);
        push(1'b1, c + 2,  "R2");
        push(1'b0, c + 5,  "R3");
        wait_to(c + 5);  other_low = 1'b1;
        wait_to(c + 12); check("R5 released while held", scl_drive_low, 0);
        check("R5 bus held low", scl_in, 0);
        push(1'b1, c + 23, "R5");
        push(1'b0, c + 26, "R5");
        wait_to(c + 20); other_low = 1'b0;
        wait_to(c + 22); check("R5 no rise yet", rise_stb, 0);
        stop_at(c + 27);
        settle("R5 all events");

        // Other master ends the high half early: R6
        start(4, 20, c);
        push(1'b1, c + 2, "R2");
        wait_to(c + 7); other_low = 1'b1;
        push(1'b0, c + 10, "R6");
        wait_to(c + 10); check("R6 drive on", scl_drive_low, 1);
        wait_to(c + 12); other_low = 1'b0;
        wait_to(c + 13); check("R6 low count restarted", scl_drive_low, 1);
        wait_to(c + 14); check("R6 released", scl_drive_low, 0);
        push(1'b1, c + 17, "R6");
        push(1'b0, c + 37, "R6");
        stop_at(c + 38);
        settle("R6 all events");

        // Disable mid high, bus toggles while off, re-enable: R8
        start(6, 10, c);
        push(1'b1, c + 2, "R2");
        stop_at(c + 6);
        wait_to(c + 7);  check("R8 released", scl_drive_low, 0);
        wait_to(c + 8);  other_low = 1'b1;
        wait_to(c + 10); other_low = 1'b0;
        wait_to(c + 11); check("R8 ignores bus", scl_drive_low, 0);
        wait_to(c + 12);
        start(6, 10, c2);
        push(1'b1, c2 + 2,  "R8");
        push(1'b0, c2 + 12, "R8");
        stop_at(c2 + 13);
        settle("R8 all events");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule